// File: doc/BRIEF.md
# Dual Shadowed Compare Unit

This unit keeps two compare values, A and B, that a PWM action stage compares against the running time-base count. Each value sits behind its own shadow register. Software-side writes either land in the active value at once, or are parked in the shadow. A parked value moves into the active value only at a load point chosen per compare: counter zero, counter equal to period, either of those, or never (frozen). Staging values this way lets a new duty take effect on a clean period boundary instead of in the middle of a pulse.

Every cycle the unit compares the count with both active values. A hit produces a one-cycle strobe. Each strobe is split by the count direction seen in the cycle of the hit, so there are four strobes: A up, A down, B up and B down. A per-compare pending flag shows that a shadow value is waiting to be transferred.

Top module: `dual_cmp_unit`

## Requirements
- R1: While reset is asserted and in the first cycle after it, both active values are 0, both pending flags are 0 and all four match strobes are 0.
- R2: A write with its compare's mode bit at 0 (immediate) sets that active value to the written data in the next cycle. It also discards any pending shadow value, so the pending flag reads 0 in the next cycle. An immediate write takes priority over a transfer in the same cycle.
- R3: A write with its compare's mode bit at 1 (shadowed) leaves the active value unchanged, stores the data in the shadow and sets the pending flag in the next cycle. A second shadowed write before a transfer replaces the waiting value.
- R4: The load-point code of each compare selects when the transfer happens: 0 at the zero event, 1 at the period event, 2 at either event. A transfer copies the shadow into the active value in the next cycle and clears the pending flag.
- R5: Load-point code 3 freezes the compare. No transfer ever happens, the active value changes only through immediate writes, and a pending flag stays set.
- R6: When the zero and period events fall in the same cycle, the value waiting before that cycle is transferred exactly once. A shadowed write made in that same cycle is not transferred and remains pending.
- R7: A load event with no pending value leaves the active value unchanged.
- R8: When the count equals an active value, that compare's up strobe pulses for one cycle in the next cycle if the direction input was 1 (counting up), or its down strobe if the direction input was 0. The comparison uses the active value held before any update in that cycle. The value 0 is valid and matches a count of 0.
- R9: The two compares are independent. The write select value 0 addresses A and 1 addresses B. Mode bit 0 and load-point input load_sel_a belong to A; mode bit 1 and load_sel_b belong to B.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tb_count | input | 16 | Time-base count |
| zero_evt | input | 1 | Count-equals-zero event |
| prd_evt | input | 1 | Count-equals-period event |
| count_up | input | 1 | Count direction, 1 counting up, 0 counting down |
| wr_en | input | 1 | Compare write strobe |
| wr_sel | input | 1 | Write target, 0 for A, 1 for B |
| wr_data | input | 16 | Compare write data |
| shadow_mode | input | 2 | Per-compare mode, bit 0 A, bit 1 B; 1 shadowed, 0 immediate |
| load_sel_a | input | 2 | Load point of A: 0 zero, 1 period, 2 either, 3 frozen |
| load_sel_b | input | 2 | Load point of B, same encoding |
| cmp_a | output | 16 | Active compare value A |
| cmp_b | output | 16 | Active compare value B |
| shadow_full | output | 2 | Pending shadow flag, bit 0 A, bit 1 B |
| match_a_up | output | 1 | A matched while counting up |
| match_a_dn | output | 1 | A matched while counting down |
| match_b_up | output | 1 | B matched while counting up |
| match_b_dn | output | 1 | B matched while counting down |

## Verification
The hardest situation to reach is a cycle in which the zero and period events coincide while a value is waiting and a new shadowed write arrives. This is where single transfer and the pending flag surviving the cycle both have to hold. The stimulus sets the period to 0 in up-down mode, so both events occur together on every cycle. Random shadowed and immediate writes to both compares are then applied, so transfer-plus-write and immediate-beats-transfer collisions happen many times. Earlier phases run up-count and up-down time bases with written values inside the count range, so every compare is matched in both directions, including value 0.

// File: rtl/cmp_pkg.sv
package cmp_pkg;

   typedef enum logic [1:0] {
      LD_AT_ZERO   = 2'd0,
      LD_AT_PERIOD = 2'd1,
      LD_AT_EITHER = 2'd2,
      LD_FROZEN    = 2'd3
   } load_pt_e;

   localparam int unsigned NUM_CMP = 2;

endpackage

// File: rtl/cmp_load_decode.sv
module cmp_load_decode
   import cmp_pkg::*;
(
   input  load_pt_e sel,
   input  logic     zero_evt,
   input  logic     prd_evt,
   output logic     load_now
);

   always_comb begin
      unique case (sel)
         LD_AT_ZERO:   load_now = zero_evt;
         LD_AT_PERIOD: load_now = prd_evt;
         LD_AT_EITHER: load_now = zero_evt | prd_evt;
         default:      load_now = 1'b0;
      endcase
   end

endmodule

// File: rtl/cmp_shadow_stage.sv
module cmp_shadow_stage
   import cmp_pkg::*;
#(
   parameter int unsigned VAL_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr,
   input  logic             shadowed,
   input  logic [VAL_W-1:0] wr_val,
   input  logic             load_now,
   input  load_pt_e         sel,
   output logic [VAL_W-1:0] active,
   output logic             pending
);

   logic [VAL_W-1:0] shadow_q;
   logic             imm_wr;
   logic             shd_wr;
   logic             xfer;

   assign imm_wr = wr & ~shadowed;
   assign shd_wr = wr & shadowed;
   assign xfer   = load_now & pending & ~imm_wr;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         active   <= '0;
         shadow_q <= '0;
         pending  <= 1'b0;
      end else if (imm_wr) begin
         active  <= wr_val;
         pending <= 1'b0;
      end else begin
         if (xfer) begin
            active <= shadow_q;
         end
         if (shd_wr) begin
            shadow_q <= wr_val;
            pending  <= 1'b1;
         end else if (xfer) begin
            pending <= 1'b0;
         end
      end
   end

   // R7: with nothing waiting and no immediate write, active holds
   assert_hold_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (!pending && !imm_wr) |=> $stable(active));

   // R5: a frozen compare changes only through immediate writes
   assert_frozen_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (sel == LD_FROZEN && !imm_wr) |=> ($stable(active) && (pending || !$past(pending))));

   // R4: transfer copies the waiting value and empties the shadow
   assert_transfer_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (load_now && pending && !wr) |=> (active == $past(shadow_q) && !pending));

   // R6: a shadowed write always leaves a value waiting
   assert_write_pending_R6: assert property (@(posedge clk) disable iff (!rst_n)
      shd_wr |=> (pending && shadow_q == $past(wr_val)));

   // R2: immediate write lands and drops the waiting value
   assert_immediate_R2: assert property (@(posedge clk) disable iff (!rst_n)
      imm_wr |=> (active == $past(wr_val) && !pending));

endmodule

// File: rtl/cmp_match_det.sv
module cmp_match_det #(
   parameter int unsigned VAL_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [VAL_W-1:0] count,
   input  logic [VAL_W-1:0] active,
   input  logic             count_up,
   output logic             hit_up,
   output logic             hit_dn
);

   logic equal;

   assign equal = (count == active);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         hit_up <= 1'b0;
         hit_dn <= 1'b0;
      end else begin
         hit_up <= equal & count_up;
         hit_dn <= equal & ~count_up;
      end
   end

   // R8: a strobe reflects the compare seen one cycle earlier
   assert_strobe_cause_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (hit_up || hit_dn) |-> ($past(count) == $past(active)));

endmodule

// File: rtl/dual_cmp_unit.sv
module dual_cmp_unit
   import cmp_pkg::*;
#(
   parameter int unsigned CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [CNT_W-1:0] tb_count,
   input  logic             zero_evt,
   input  logic             prd_evt,
   input  logic             count_up,
   input  logic             wr_en,
   input  logic             wr_sel,
   input  logic [CNT_W-1:0] wr_data,
   input  logic [1:0]       shadow_mode,
   input  logic [1:0]       load_sel_a,
   input  logic [1:0]       load_sel_b,
   output logic [CNT_W-1:0] cmp_a,
   output logic [CNT_W-1:0] cmp_b,
   output logic [1:0]       shadow_full,
   output logic             match_a_up,
   output logic             match_a_dn,
   output logic             match_b_up,
   output logic             match_b_dn
);

   localparam int unsigned SEL_W = $clog2(NUM_CMP);

   generate
      if (CNT_W < 2 || CNT_W > 32) begin : g_bad_width
         $error("dual_cmp_unit: CNT_W must lie in 2..32");
      end
      if (SEL_W != 1) begin : g_bad_count
         $error("dual_cmp_unit: port map expects exactly two compares");
      end
   endgenerate

   logic [CNT_W-1:0] act_v [NUM_CMP];
   logic [1:0]       sel_raw [NUM_CMP];
   logic [NUM_CMP-1:0] up_v;
   logic [NUM_CMP-1:0] dn_v;

   assign sel_raw[0] = load_sel_a;
   assign sel_raw[1] = load_sel_b;

   for (genvar g = 0; g < NUM_CMP; g++) begin : g_cmp
      load_pt_e sel_e;
      logic     ld;
      logic     wr_mine;

      assign sel_e   = load_pt_e'(sel_raw[g]);
      assign wr_mine = wr_en & (wr_sel == SEL_W'(g));

      cmp_load_decode u_dec (
         .sel      (sel_e),
         .zero_evt (zero_evt),
         .prd_evt  (prd_evt),
         .load_now (ld)
      );

      cmp_shadow_stage #(.VAL_W(CNT_W)) u_stage (
         .clk      (clk),
         .rst_n    (rst_n),
         .wr       (wr_mine),
         .shadowed (shadow_mode[g]),
         .wr_val   (wr_data),
         .load_now (ld),
         .sel      (sel_e),
         .active   (act_v[g]),
         .pending  (shadow_full[g])
      );

      cmp_match_det #(.VAL_W(CNT_W)) u_match (
         .clk      (clk),
         .rst_n    (rst_n),
         .count    (tb_count),
         .active   (act_v[g]),
         .count_up (count_up),
         .hit_up   (up_v[g]),
         .hit_dn   (dn_v[g])
      );
   end

   assign cmp_a      = act_v[0];
   assign cmp_b      = act_v[1];
   assign match_a_up = up_v[0];
   assign match_a_dn = dn_v[0];
   assign match_b_up = up_v[1];
   assign match_b_dn = dn_v[1];

   // R9: a write to A never disturbs B in the next cycle
   assert_isolated_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && !wr_sel && !prd_evt && !zero_evt) |=> $stable(cmp_b));

   // R1: nothing pending or matched right after reset
   assert_reset_R1: assert property (@(posedge clk)
      !rst_n |=> (shadow_full == 2'b00 && !match_a_up && !match_b_dn));

endmodule

// File: tb/tb_dual_cmp_unit.sv
module tb_dual_cmp_unit;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [15:0] tb_count = '0;
   logic        zero_evt = 1'b0;
   logic        prd_evt = 1'b0;
   logic        count_up = 1'b1;
   logic        wr_en = 1'b0;
   logic        wr_sel = 1'b0;
   logic [15:0] wr_data = '0;
   logic [1:0]  shadow_mode = '0;
   logic [1:0]  load_sel_a = '0;
   logic [1:0]  load_sel_b = '0;
   logic [15:0] cmp_a, cmp_b;
   logic [1:0]  shadow_full;
   logic        match_a_up, match_a_dn, match_b_up, match_b_dn;

   always #10 clk = ~clk;

   dual_cmp_unit dut (
      .clk(clk), .rst_n(rst_n), .tb_count(tb_count), .zero_evt(zero_evt),
      .prd_evt(prd_evt), .count_up(count_up), .wr_en(wr_en), .wr_sel(wr_sel),
      .wr_data(wr_data), .shadow_mode(shadow_mode), .load_sel_a(load_sel_a),
      .load_sel_b(load_sel_b), .cmp_a(cmp_a), .cmp_b(cmp_b),
      .shadow_full(shadow_full), .match_a_up(match_a_up),
      .match_a_dn(match_a_dn), .match_b_up(match_b_up), .match_b_dn(match_b_dn)
   );

   int checks = 0;
   int errors = 0;
   bit finished = 1'b0;
   string tag = "R1";

   // reference state
   int m_act [2];
   int m_shd [2];
   bit m_full [2];
   bit m_up [2];
   bit m_dn [2];

   // time-base state
   int  cnt = 0;
   int  per = 9;
   bit  dir = 1'b1;
   bit  updown = 1'b0;
   int  wr_pct = 30;
   int  shd_pct = 60;

   task automatic check(input string what, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s %s: got %0d expected %0d at %0t", tag, what, act, exp, $time);
      end
   endtask

   function automatic bit load_hit(input int sel, input bit z, input bit p);
      case (sel)
         0: return z;
         1: return p;
         2: return z | p;
         default: return 1'b0;
      endcase
   endfunction

   task automatic model_step();
      for (int ch = 0; ch < 2; ch++) begin
         int  sel;
         bit  wr;
         bit  ld;
         sel = (ch == 0) ? int'(load_sel_a) : int'(load_sel_b);
         wr  = wr_en && (int'(wr_sel) == ch);
         ld  = load_hit(sel, zero_evt, prd_evt);
         m_up[ch] = (int'(tb_count) == m_act[ch]) && count_up;
         m_dn[ch] = (int'(tb_count) == m_act[ch]) && !count_up;
         if (!rst_n) begin
            m_act[ch] = 0; m_shd[ch] = 0; m_full[ch] = 0;
            m_up[ch] = 0; m_dn[ch] = 0;
         end else if (wr && !shadow_mode[ch]) begin
            m_act[ch] = int'(wr_data);
            m_full[ch] = 0;
         end else begin
            if (ld && m_full[ch]) begin
               m_act[ch] = m_shd[ch];
               m_full[ch] = 0;
            end
            if (wr && shadow_mode[ch]) begin
               m_shd[ch] = int'(wr_data);
               m_full[ch] = 1;
            end
         end
      end
   endtask

   task automatic compare_all();
      check("cmp_a", int'(cmp_a), m_act[0]);
      check("cmp_b", int'(cmp_b), m_act[1]);
      check("shadow_full[0]", int'(shadow_full[0]), int'(m_full[0]));
      check("shadow_full[1]", int'(shadow_full[1]), int'(m_full[1]));
      check("match_a_up R8", int'(match_a_up), int'(m_up[0]));
      check("match_a_dn R8", int'(match_a_dn), int'(m_dn[0]));
      check("match_b_up R8", int'(match_b_up), int'(m_up[1]));
      check("match_b_dn R8", int'(match_b_dn), int'(m_dn[1]));
   endtask

   task automatic advance_timebase();
      if (!updown) begin
         dir = 1'b1;
         cnt = (cnt >= per) ? 0 : cnt + 1;
      end else if (dir) begin
         if (cnt >= per) begin
            dir = 1'b0;
            cnt = (per == 0) ? 0 : cnt - 1;
         end else cnt = cnt + 1;
      end else begin
         if (cnt == 0) begin
            dir = 1'b1;
            cnt = (per == 0) ? 0 : 1;
         end else cnt = cnt - 1;
      end
      tb_count = 16'(cnt);
      zero_evt = (cnt == 0);
      prd_evt  = (cnt == per);
      count_up = dir;
   endtask

   task automatic drive_writes();
      wr_en = ($urandom_range(99, 0) < wr_pct);
      wr_sel = 1'($urandom_range(1, 0));
      wr_data = 16'($urandom_range(per, 0));
      shadow_mode[0] = ($urandom_range(99, 0) < shd_pct);
      shadow_mode[1] = ($urandom_range(99, 0) < shd_pct);
   endtask

   task automatic run_cycles(input int n);
      for (int i = 0; i < n; i++) begin
         @(posedge clk);
         model_step();
         @(negedge clk);
         if (finished) return;
         compare_all();
         advance_timebase();
         drive_writes();
      end
   endtask

   initial begin : watchdog
      repeat (200000) @(posedge clk);
      if (!finished) begin
         finished = 1'b1;
         errors++;
         checks++;
         $display("FAIL watchdog expired: got 1 expected 0");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin : stim
      for (int ch = 0; ch < 2; ch++) begin
         m_act[ch] = 0; m_shd[ch] = 0; m_full[ch] = 0; m_up[ch] = 0; m_dn[ch] = 0;
      end
      // R1: reset state, inputs busy during reset
      tag = "R1";
      wr_en = 1'b1; wr_data = 16'd5; shadow_mode = 2'b00;
      repeat (3) begin
         @(posedge clk); model_step();
         @(negedge clk); compare_all();
      end
      rst_n = 1'b1;
      wr_en = 1'b0;
      tb_count = 16'hFFFF; // nothing matches first cycle
      count_up = 1'b1;
      @(posedge clk); model_step();
      @(negedge clk); compare_all();

      // R2 R3 R4 R7 R8 R9: up count, A at zero, B at period
      tag = "R2 R3 R4 R7 R8 R9 up";
      updown = 1'b0; per = 9; cnt = 0;
      load_sel_a = 2'd0; load_sel_b = 2'd1;
      run_cycles(400);

      // R4 R8: up-down, A at either, B at zero
      tag = "R4 R8 R9 updown";
      updown = 1'b1; per = 7; cnt = 0; dir = 1'b1;
      load_sel_a = 2'd2; load_sel_b = 2'd0;
      run_cycles(400);

      // R5: both frozen, mostly shadowed writes
      tag = "R5 frozen";
      load_sel_a = 2'd3; load_sel_b = 2'd3;
      shd_pct = 85;
      run_cycles(200);

      // R6: period 0 makes zero and period coincide every cycle
      tag = "R6 coincident events";
      per = 0; cnt = 0; updown = 1'b1;
      load_sel_a = 2'd2; load_sel_b = 2'd2;
      wr_pct = 60; shd_pct = 70;
      run_cycles(300);

      // R7: loads with nothing waiting, mixed points
      tag = "R7 idle loads";
      per = 5; updown = 1'b0; cnt = 0;
      load_sel_a = 2'd1; load_sel_b = 2'd2;
      wr_pct = 5; shd_pct = 0;
      run_cycles(150);

      if (!finished) begin
         finished = 1'b1;
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

endmodule